// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of a 14-bit parallel-input converter. It takes one command at a time from a valid/ready port and turns it into a strobe sequence on the converter's pins. Each command carries a data code and one of four operations. The block drives the data bus and generates three strobes: an active-low write strobe that captures the bus into the converter's input stage, an active-high load strobe that moves the input stage to the output stage, and an active-low clear strobe.

Every interval is counted in system clock cycles. The count comes from a nanosecond figure and a clock-period parameter, so one netlist meets the converter's timing at any clock rate. There are two sets of nanosecond figures: one for nominal supply and one for low supply. A profile input picks one of them per command. It is sampled only when the command is accepted.

Top module: `dac_strobe_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1, `dac_wr_n` is 1, `dac_ld` is 0, `dac_clr_n` is 1 and `dac_data` is 0.
- R2: The operation codes on `cmd_op` are 0 = write only, 1 = load only, 2 = write then load, 3 = clear. In the cycle after a write or write-then-load command is accepted, `dac_data` shows the command's code and `dac_wr_n` goes low. `dac_wr_n` stays low for W cycles, where W is the larger of the setup count and the write-width count of the selected profile.
- R3: `dac_data` does not change on any cycle in which `dac_wr_n` stays low.
- R4: A load-only command drives `dac_ld` high for L cycles, starting the cycle after acceptance. During this command `dac_data` and `dac_wr_n` are unchanged.
- R5: For write then load, `dac_ld` rises exactly G cycles after `dac_wr_n` returns high, where G is the gap count. During those G cycles no strobe is active. `dac_ld` then stays high for L cycles.
- R6: A clear command drives `dac_clr_n` low for C cycles, starting the cycle after acceptance. `dac_data`, `dac_wr_n` and `dac_ld` are left untouched.
- R7: `cmd_ready` falls in the cycle after acceptance. It stays low while any strobe is active and for one further idle cycle after the last strobe returns, then rises. While `cmd_ready` is low, `cmd_valid` has no effect.
- R8: `profile_lv` (1 = low-voltage figures, 0 = nominal figures) is sampled at acceptance. Changing it during a sequence does not change that sequence's lengths.
- R9: Each cycle count equals the ceiling of (ns × 1000 / `CLK_PERIOD_PS`), and is never less than 1.
- R10: At most one of the three strobes is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| profile_lv | input | 1 | Timing profile: 1 = low-voltage, 0 = nominal |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer can accept a command |
| cmd_op | input | 2 | Operation: 0 write, 1 load, 2 write then load, 3 clear |
| cmd_code | input | DATA_W | Code to place on the bus |
| dac_data | output | DATA_W | Parallel data bus to the converter |
| dac_wr_n | output | 1 | Active-low write strobe |
| dac_ld | output | 1 | Active-high load strobe |
| dac_clr_n | output | 1 | Active-low clear strobe |

## Verification
Some properties are checked by assertions on every cycle:
- the strobes never overlap;
- the handshake drops ready right after acceptance and keeps it low while any strobe is active;
- the bus holds steady while the write strobe stays low;
- a clear pulse leaves the bus alone.

Other behaviour only the directed scenarios can show, because each needs a full recorded trace compared against the expected waveform:
- the exact pulse lengths in each profile;
- the write-to-load gap;
- the single idle cycle before ready returns;
- that a profile change in mid-sequence is ignored;
- that a command held during a busy period is taken only afterwards.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_LOAD   = 2'd1,
        OP_WRLOAD = 2'd2,
        OP_CLEAR  = 2'd3
    } dac_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR,
        S_GAP,
        S_LD,
        S_CLR,
        S_TAIL
    } seq_state_e;

    // Cycles needed to cover ns nanoseconds at period_ps, never below one.
    function automatic int cycles_for(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_seq_timing.sv
module dac_seq_timing
    import dac_seq_pkg::*;
#(
    parameter int CNT_W         = 4,
    parameter int CLK_PERIOD_PS = 20000,
    parameter int NOM_SETUP_NS  = 20,
    parameter int NOM_WR_NS     = 20,
    parameter int NOM_LD_NS     = 20,
    parameter int NOM_CLR_NS    = 20,
    parameter int LV_SETUP_NS   = 35,
    parameter int LV_WR_NS      = 35,
    parameter int LV_LD_NS      = 35,
    parameter int LV_CLR_NS     = 35,
    parameter int GAP_NS        = 0
) (
    input  logic             lv_i,
    output logic [CNT_W-1:0] wr_cyc_o,
    output logic [CNT_W-1:0] ld_cyc_o,
    output logic [CNT_W-1:0] clr_cyc_o,
    output logic [CNT_W-1:0] gap_cyc_o
);

    // The write strobe must cover both the data setup and its own width.
    localparam int NOM_WR_C  = imax(cycles_for(NOM_SETUP_NS, CLK_PERIOD_PS),
                                    cycles_for(NOM_WR_NS, CLK_PERIOD_PS));
    localparam int LV_WR_C   = imax(cycles_for(LV_SETUP_NS, CLK_PERIOD_PS),
                                    cycles_for(LV_WR_NS, CLK_PERIOD_PS));
    localparam int NOM_LD_C  = cycles_for(NOM_LD_NS, CLK_PERIOD_PS);
    localparam int LV_LD_C   = cycles_for(LV_LD_NS, CLK_PERIOD_PS);
    localparam int NOM_CLR_C = cycles_for(NOM_CLR_NS, CLK_PERIOD_PS);
    localparam int LV_CLR_C  = cycles_for(LV_CLR_NS, CLK_PERIOD_PS);
    localparam int GAP_C     = cycles_for(GAP_NS, CLK_PERIOD_PS);

    always_comb begin
        if (lv_i) begin
            wr_cyc_o  = CNT_W'(LV_WR_C);
            ld_cyc_o  = CNT_W'(LV_LD_C);
            clr_cyc_o = CNT_W'(LV_CLR_C);
        end else begin
            wr_cyc_o  = CNT_W'(NOM_WR_C);
            ld_cyc_o  = CNT_W'(NOM_LD_C);
            clr_cyc_o = CNT_W'(NOM_CLR_C);
        end
        gap_cyc_o = CNT_W'(GAP_C);
    end

endmodule

// File: rtl/dac_seq_timer.sv
module dac_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == '0);

endmodule

// File: rtl/dac_strobe_seq.sv
module dac_strobe_seq
    import dac_seq_pkg::*;
#(
    parameter int DATA_W        = 14,
    parameter int CLK_PERIOD_PS = 20000,
    parameter int NOM_SETUP_NS  = 20,
    parameter int NOM_WR_NS     = 20,
    parameter int NOM_LD_NS     = 20,
    parameter int NOM_CLR_NS    = 20,
    parameter int LV_SETUP_NS   = 35,
    parameter int LV_WR_NS      = 35,
    parameter int LV_LD_NS      = 35,
    parameter int LV_CLR_NS     = 35,
    parameter int GAP_NS        = 0
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              profile_lv,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_code,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_wr_n,
    output logic              dac_ld,
    output logic              dac_clr_n
);

    localparam int MAX_NS = imax(imax(imax(NOM_SETUP_NS, NOM_WR_NS), imax(NOM_LD_NS, NOM_CLR_NS)),
                                 imax(imax(imax(LV_SETUP_NS, LV_WR_NS), imax(LV_LD_NS, LV_CLR_NS)),
                                      GAP_NS));
    localparam int MAX_C  = cycles_for(MAX_NS, CLK_PERIOD_PS);
    localparam int CNT_W  = $clog2(MAX_C + 1);

    typedef struct packed {
        seq_state_e        st;
        logic              rdy;
        logic              wr_n;
        logic              ld;
        logic              clr_n;
        logic              lv;
        dac_op_e           op;
        logic [DATA_W-1:0] data;
    } seq_regs_t;

    seq_regs_t         r_d, r_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_last;
    logic              prof_sel;
    logic [CNT_W-1:0]  wr_cyc, ld_cyc, clr_cyc, gap_cyc;

    // Profile is taken live while idle, then held for the whole sequence.
    assign prof_sel = (r_q.st == S_IDLE) ? profile_lv : r_q.lv;

    dac_seq_timing #(
        .CNT_W        (CNT_W),
        .CLK_PERIOD_PS(CLK_PERIOD_PS),
        .NOM_SETUP_NS (NOM_SETUP_NS),
        .NOM_WR_NS    (NOM_WR_NS),
        .NOM_LD_NS    (NOM_LD_NS),
        .NOM_CLR_NS   (NOM_CLR_NS),
        .LV_SETUP_NS  (LV_SETUP_NS),
        .LV_WR_NS     (LV_WR_NS),
        .LV_LD_NS     (LV_LD_NS),
        .LV_CLR_NS    (LV_CLR_NS),
        .GAP_NS       (GAP_NS)
    ) u_timing (
        .lv_i     (prof_sel),
        .wr_cyc_o (wr_cyc),
        .ld_cyc_o (ld_cyc),
        .clr_cyc_o(clr_cyc),
        .gap_cyc_o(gap_cyc)
    );

    dac_seq_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_ni(rst_ni),
        .load_i(tmr_load),
        .val_i (tmr_val),
        .last_o(tmr_last)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    r_d.rdy  = 1'b0;
                    r_d.lv   = profile_lv;
                    r_d.op   = dac_op_e'(cmd_op);
                    tmr_load = 1'b1;
                    unique case (dac_op_e'(cmd_op))
                        OP_WRITE, OP_WRLOAD: begin
                            r_d.data = cmd_code;
                            r_d.wr_n = 1'b0;
                            tmr_val  = wr_cyc - 1'b1;
                            r_d.st   = S_WR;
                        end
                        OP_LOAD: begin
                            r_d.ld  = 1'b1;
                            tmr_val = ld_cyc - 1'b1;
                            r_d.st  = S_LD;
                        end
                        default: begin
                            r_d.clr_n = 1'b0;
                            tmr_val   = clr_cyc - 1'b1;
                            r_d.st    = S_CLR;
                        end
                    endcase
                end
            end
            S_WR: begin
                if (tmr_last) begin
                    r_d.wr_n = 1'b1;
                    if (r_q.op == OP_WRLOAD) begin
                        tmr_load = 1'b1;
                        tmr_val  = gap_cyc - 1'b1;
                        r_d.st   = S_GAP;
                    end else begin
                        r_d.st = S_TAIL;
                    end
                end
            end
            S_GAP: begin
                if (tmr_last) begin
                    r_d.ld   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = ld_cyc - 1'b1;
                    r_d.st   = S_LD;
                end
            end
            S_LD: begin
                if (tmr_last) begin
                    r_d.ld = 1'b0;
                    r_d.st = S_TAIL;
                end
            end
            S_CLR: begin
                if (tmr_last) begin
                    r_d.clr_n = 1'b1;
                    r_d.st    = S_TAIL;
                end
            end
            default: begin
                r_d.rdy = 1'b1;
                r_d.st  = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st    <= S_IDLE;
            r_q.rdy   <= 1'b1;
            r_q.wr_n  <= 1'b1;
            r_q.ld    <= 1'b0;
            r_q.clr_n <= 1'b1;
            r_q.lv    <= 1'b0;
            r_q.op    <= OP_WRITE;
            r_q.data  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_ready = r_q.rdy;
    assign dac_data  = r_q.data;
    assign dac_wr_n  = r_q.wr_n;
    assign dac_ld    = r_q.ld;
    assign dac_clr_n = r_q.clr_n;

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_ni)
        $countones({~dac_wr_n, dac_ld, ~dac_clr_n}) <= 1);

    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_ni)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r7_no_ready_in_strobe: assert property (@(posedge clk) disable iff (!rst_ni)
        (!dac_wr_n || dac_ld || !dac_clr_n) |-> !cmd_ready);

    a_r3_bus_held_in_write: assert property (@(posedge clk) disable iff (!rst_ni)
        (!dac_wr_n && $past(!dac_wr_n)) |-> $stable(dac_data));

    a_r6_clear_keeps_bus: assert property (@(posedge clk) disable iff (!rst_ni)
        !dac_clr_n |=> $stable(dac_data));

endmodule

// File: tb/dac_strobe_seq_bench.sv
module dac_strobe_seq_bench;

    localparam int DW    = 14;
    localparam int PER   = 4000;
    localparam int NMAX  = 48;

    // Expected counts (R9): ceil(ns*1000/PER), at least 1.
    function automatic int cyc(input int ns);
        int c;
        c = (ns * 1000 + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          profile_lv = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = 2'd0;
    logic [DW-1:0] cmd_code = '0;
    logic [DW-1:0] dac_data;
    logic          dac_wr_n, dac_ld, dac_clr_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic          s_wr[NMAX], s_ld[NMAX], s_clr[NMAX], s_rdy[NMAX];
    logic [DW-1:0] s_dat[NMAX];
    logic          e_wr[NMAX], e_ld[NMAX], e_clr[NMAX], e_rdy[NMAX];
    logic [DW-1:0] bus_now = '0;

    always #10 clk = ~clk;

    dac_strobe_seq #(
        .DATA_W(DW), .CLK_PERIOD_PS(PER),
        .NOM_SETUP_NS(20), .NOM_WR_NS(24), .NOM_LD_NS(20), .NOM_CLR_NS(28),
        .LV_SETUP_NS(35), .LV_WR_NS(35), .LV_LD_NS(40), .LV_CLR_NS(35),
        .GAP_NS(10)
    ) u_dac_strobe_seq (
        .clk(clk), .rst_ni(rst_ni), .profile_lv(profile_lv),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_code(cmd_code), .dac_data(dac_data), .dac_wr_n(dac_wr_n),
        .dac_ld(dac_ld), .dac_clr_n(dac_clr_n)
    );

    function automatic int wlen(input bit lv);
        return lv ? mx(cyc(35), cyc(35)) : mx(cyc(20), cyc(24));
    endfunction
    function automatic int llen(input bit lv);
        return lv ? cyc(40) : cyc(20);
    endfunction
    function automatic int clen(input bit lv);
        return lv ? cyc(35) : cyc(28);
    endfunction
    function automatic int glen();
        return cyc(10);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Build the expected waveform; returns index of the tail idle cycle.
    task automatic build(input int op, input bit lv, output int tail);
        int t;
        for (int i = 0; i < NMAX; i++) begin
            e_wr[i] = 1'b1; e_ld[i] = 1'b0; e_clr[i] = 1'b1; e_rdy[i] = 1'b1;
        end
        t = 0;
        if (op == 0 || op == 2) begin
            for (int i = 0; i < wlen(lv); i++) e_wr[i] = 1'b0;
            t = wlen(lv);
            if (op == 2) begin
                t = t + glen();
                for (int i = 0; i < llen(lv); i++) e_ld[t + i] = 1'b1;
                t = t + llen(lv);
            end
        end else if (op == 1) begin
            for (int i = 0; i < llen(lv); i++) e_ld[i] = 1'b1;
            t = llen(lv);
        end else begin
            for (int i = 0; i < clen(lv); i++) e_clr[i] = 1'b0;
            t = clen(lv);
        end
        for (int i = 0; i <= t; i++) e_rdy[i] = 1'b0;
        tail = t;
    endtask

    task automatic wait_idle();
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic launch(input int op, input logic [DW-1:0] code, input bit lv);
        wait_idle();
        cmd_valid  = 1'b1;
        cmd_op     = op[1:0];
        cmd_code   = code;
        profile_lv = lv;
        @(posedge clk);
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic capture(input int n, input int flip_at);
        for (int i = 0; i < n; i++) begin
            s_wr[i] = dac_wr_n; s_ld[i] = dac_ld; s_clr[i] = dac_clr_n;
            s_rdy[i] = cmd_ready; s_dat[i] = dac_data;
            if (i == flip_at) profile_lv = ~profile_lv;
            if (i < n - 1) @(negedge clk);
        end
    endtask

    task automatic compare(input int n, input logic [DW-1:0] exp_bus,
                           input string req, input string name);
        int bw = -1, bl = -1, bc = -1, br = -1, bd = -1;
        for (int i = 0; i < n; i++) begin
            if (bw < 0 && s_wr[i]  !== e_wr[i])  bw = i;
            if (bl < 0 && s_ld[i]  !== e_ld[i])  bl = i;
            if (bc < 0 && s_clr[i] !== e_clr[i]) bc = i;
            if (br < 0 && s_rdy[i] !== e_rdy[i]) br = i;
            if (bd < 0 && s_dat[i] !== exp_bus)  bd = i;
        end
        check(bw < 0, req, {name, " wr_n trace"}, (bw < 0) ? 0 : int'(s_wr[bw]),  (bw < 0) ? 0 : int'(e_wr[bw]));
        check(bl < 0, req, {name, " ld trace"},   (bl < 0) ? 0 : int'(s_ld[bl]),  (bl < 0) ? 0 : int'(e_ld[bl]));
        check(bc < 0, req, {name, " clr_n trace"},(bc < 0) ? 0 : int'(s_clr[bc]), (bc < 0) ? 0 : int'(e_clr[bc]));
        check(br < 0, "R7", {name, " ready trace"},(br < 0) ? 0 : int'(s_rdy[br]),(br < 0) ? 0 : int'(e_rdy[br]));
        check(bd < 0, "R3", {name, " bus value"}, (bd < 0) ? 0 : int'(s_dat[bd]), int'(exp_bus));
    endtask

    task automatic scenario(input int op, input logic [DW-1:0] code, input bit lv,
                            input int flip_at, input string req, input string name);
        int tail;
        build(op, lv, tail);
        launch(op, code, lv);
        if (op == 0 || op == 2) bus_now = code;
        capture(tail + 4, flip_at);
        compare(tail + 4, bus_now, req, name);
    endtask

    task automatic t_reset_state();
        check(cmd_ready === 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);
        check(dac_wr_n  === 1'b1, "R1", "wr_n after reset", int'(dac_wr_n), 1);
        check(dac_ld    === 1'b0, "R1", "ld after reset", int'(dac_ld), 0);
        check(dac_clr_n === 1'b1, "R1", "clr_n after reset", int'(dac_clr_n), 1);
        check(dac_data  === '0,   "R1", "bus after reset", int'(dac_data), 0);
    endtask

    // R7: command held while busy is taken only after ready returns.
    task automatic t_busy_hold();
        int tail;
        build(0, 1'b0, tail);
        launch(0, 14'h2A5C, 1'b0);
        bus_now   = 14'h2A5C;
        cmd_valid = 1'b1;
        cmd_op    = 2'd3;
        cmd_code  = 14'h0F0F;
        capture(tail + 2, -1);
        compare(tail + 2, bus_now, "R7", "busy-hold write");
        build(3, 1'b0, tail);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        capture(tail + 4, -1);
        compare(tail + 4, bus_now, "R6", "held clear");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        t_reset_state();
        scenario(0, 14'h1234, 1'b0, -1, "R2", "write nominal");
        scenario(0, 14'h3FFF, 1'b1, -1, "R8", "write low-voltage");
        scenario(1, 14'h0001, 1'b0, -1, "R4", "load nominal");
        scenario(1, 14'h2222, 1'b1, -1, "R4", "load low-voltage");
        scenario(2, 14'h1FFF, 1'b0, -1, "R5", "write+load nominal");
        scenario(2, 14'h2000, 1'b1, -1, "R5", "write+load low-voltage");
        scenario(3, 14'h3333, 1'b0, -1, "R6", "clear nominal");
        scenario(3, 14'h0AAA, 1'b1, -1, "R6", "clear low-voltage");
        scenario(2, 14'h1555, 1'b1, 2,  "R8", "profile flip mid-sequence");
        scenario(0, 14'h0000, 1'b0, 1,  "R9", "write nominal after flip");
        t_busy_hold();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule